// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block turns a software write of a 32-bit command word into one command transaction on a simple card-side handshake. The command index comes from the low bits of the command word and the argument from a separate 32-bit register. When the card answers, the block checks the answer against the response type the command asked for. It packs a matching answer into four 32-bit response words and pulses either a completion flag or a no-response flag.

A command can be marked as a clock change. It then never reaches the card but still reports completion. A command can also request an automatic stop. In that case the sequencer waits until the transfer-count-zero input is high, then issues command index 12 with a zero argument by itself. It posts an auto-command-done pulse when that stop completes. The command and argument registers that software sees keep their original values throughout.

Top module: `sd_cmd_seq`

## Requirements
- R1: A command write with bit 31 set while idle starts a command: `busy` is high from the next cycle on, and `cmd_reg` holds the written word with bit 31 cleared.
- R2: A command write with bit 31 clear only updates `cmd_reg`. No request is made, no flag pulses and `busy` stays low.
- R3: When bit 21 of the command is set, no request is issued and `cmd_done` pulses one cycle after the start. The response words are unchanged.
- R4: The request carries bits 5:0 of the command as its index and `arg_reg` as its argument. `req_valid`, `req_idx` and `req_arg` stay stable until `req_ready` is seen.
- R5: With bit 6 set and bit 7 clear, a 4-byte answer (`rsp_len` = 4) writes response word 0 from `rsp_data[127:96]` (the first-received word) and clears words 1 to 3. Response word k sits at `resp_flat[32k+31:32k]`.
- R6: With bits 6 and 7 set, a 16-byte answer (`rsp_len` = 16) fills the words in reversed arrival order. Word 3 gets the first-received word `rsp_data[127:96]`, and word 0 gets the last-received word `rsp_data[31:0]`.
- R7: With bit 6 set, an answer whose length does not match the requested type, or a length code of 0, pulses `no_rsp` instead of `cmd_done` and leaves the response words unchanged. The two flags never pulse together.
- R8: With bit 6 clear, any answer pulses `cmd_done` and leaves the response words unchanged.
- R9: With bit 12 set, after the main command has completed and once `xfer_zero` is high, a second request with index 12 and argument 0 is issued. Its completion or no-response flag pulses in the same cycle as `autocmd_done`.
- R10: The automatic stop leaves `cmd_reg` and `arg_reg` at the values software wrote.
- R11: `busy` stays high from the start until the final flag, and it falls in the cycle that flag pulses. That final flag is `autocmd_done` when a stop runs. No request is made while `busy` is low.
- R12: Command and argument writes that arrive while `busy` is high are ignored. They start nothing and change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument to write |
| xfer_zero | input | 1 | Remaining data transfer count is zero |
| req_valid | output | 1 | Card request valid |
| req_ready | input | 1 | Card accepts the request |
| req_idx | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_valid | input | 1 | Card answer strobe |
| rsp_len | input | 5 | Answer length code: 0 none, 4 short, 16 long |
| rsp_data | input | 128 | Answer data, first-received word in bits 127:96 |
| cmd_reg | output | 32 | Software-visible command register |
| arg_reg | output | 32 | Software-visible argument register |
| resp_flat | output | 128 | Response words, word k at bits 32k+31:32k |
| busy | output | 1 | Command sequence in progress |
| cmd_done | output | 1 | Completion pulse |
| no_rsp | output | 1 | No-response or length-mismatch pulse |
| autocmd_done | output | 1 | Automatic stop finished pulse |

## Verification
The bench goes after the answer-length mismatches in both directions and the empty answer. A design that compared only the response bit would overwrite the response words and report completion where `no_rsp` belongs. Long answers carry a distinct pattern in each word, so a packer that kept arrival order puts the first word in word 0 and shows up at once. For the automatic stop, the bench holds `xfer_zero` low for several cycles and gives the stop a mismatched answer. A sequencer that did not wait, or that drove the stop through the software registers, would issue the second request early or leave `cmd_reg` reading index 12. Writes poked in during a stalled handshake would restart the sequence or corrupt the registers if the busy guard were missing.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
   // command word bit positions
   localparam int START_BIT    = 31;
   localparam int CLKCHG_BIT   = 21;
   localparam int AUTOSTOP_BIT = 12;
   localparam int RSP_LONG_BIT = 7;
   localparam int RSP_EXP_BIT  = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_REQ   = 2'd1,
      ST_RSP   = 2'd2,
      ST_XWAIT = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic start;
      logic clk_only;
      logic auto_stop;
      logic rsp_long;
      logic rsp_exp;
   } cmd_flags_t;
endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
   import sd_cmd_pkg::*;
#(
   parameter int W     = 32,
   parameter int IDX_W = 6
) (
   input  logic [W-1:0]     word,
   output cmd_flags_t       flags,
   output logic [IDX_W-1:0] idx
);
   if (W <= START_BIT) begin : g_bad_w
      $error("command word too narrow for start bit");
   end
   if (IDX_W >= RSP_EXP_BIT + 1) begin : g_bad_idx
      $error("index field overlaps response flags");
   end

   always_comb begin
      flags.start     = word[START_BIT];
      flags.clk_only  = word[CLKCHG_BIT];
      flags.auto_stop = word[AUTOSTOP_BIT];
      flags.rsp_long  = word[RSP_LONG_BIT];
      flags.rsp_exp   = word[RSP_EXP_BIT];
      idx             = word[IDX_W-1:0];
   end
endmodule

// File: rtl/sd_rsp_pack.sv
module sd_rsp_pack #(
   parameter int W      = 32,
   parameter int NWORDS = 4,
   parameter int LEN_W  = 5
) (
   input  logic                rsp_exp,
   input  logic                rsp_long,
   input  logic [LEN_W-1:0]    rsp_len,
   input  logic [W*NWORDS-1:0] rsp_data,
   input  logic [W*NWORDS-1:0] cur_resp,
   output logic                ok,
   output logic [W*NWORDS-1:0] nxt_resp
);
   localparam int SHORT_BYTES = W / 8;
   localparam int LONG_BYTES  = W * NWORDS / 8;
   localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(SHORT_BYTES);
   localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(LONG_BYTES);

   if (LONG_BYTES >= (1 << LEN_W)) begin : g_bad_len
      $error("length code too narrow for long response");
   end

   logic [W*NWORDS-1:0] short_img;
   logic [W*NWORDS-1:0] long_img;

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      // long: word k takes arrival slot k (first arrival is the top slot)
      assign long_img[W*k +: W] = rsp_data[W*k +: W];
      if (k == 0) begin : g_first
         assign short_img[W*k +: W] = rsp_data[W*(NWORDS-1) +: W];
      end else begin : g_rest
         assign short_img[W*k +: W] = '0;
      end
   end

   always_comb begin
      if (!rsp_exp)     ok = 1'b1;
      else if (rsp_long) ok = (rsp_len == LEN_LONG);
      else               ok = (rsp_len == LEN_SHORT);
      if (rsp_exp && ok) nxt_resp = rsp_long ? long_img : short_img;
      else               nxt_resp = cur_resp;
   end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
   import sd_cmd_pkg::*;
#(
   parameter int W         = 32,
   parameter int IDX_W     = 6,
   parameter int RSP_WORDS = 4,
   parameter int LEN_W     = 5,
   parameter int STOP_IDX  = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_wr,
   input  logic [W-1:0]           cmd_wdata,
   input  logic                   arg_wr,
   input  logic [W-1:0]           arg_wdata,
   input  logic                   xfer_zero,
   output logic                   req_valid,
   input  logic                   req_ready,
   output logic [IDX_W-1:0]       req_idx,
   output logic [W-1:0]           req_arg,
   input  logic                   rsp_valid,
   input  logic [LEN_W-1:0]       rsp_len,
   input  logic [W*RSP_WORDS-1:0] rsp_data,
   output logic [W-1:0]           cmd_reg,
   output logic [W-1:0]           arg_reg,
   output logic [W*RSP_WORDS-1:0] resp_flat,
   output logic                   busy,
   output logic                   cmd_done,
   output logic                   no_rsp,
   output logic                   autocmd_done
);
   localparam int RW = W * RSP_WORDS;
   localparam logic [W-1:0] START_MASK = W'(1) << START_BIT;
   localparam logic [IDX_W-1:0] STOP_CODE = IDX_W'(STOP_IDX);

   if (STOP_IDX >= (1 << IDX_W)) begin : g_bad_stop
      $error("stop index does not fit the index field");
   end

   seq_state_t        state;
   logic              in_stop;
   cmd_flags_t        f;
   logic [IDX_W-1:0]  idx;
   logic              pk_ok;
   logic [RW-1:0]     pk_resp;
   logic              finish, fin_ok, load_go;

   sd_cmd_decode #(.W(W), .IDX_W(IDX_W)) u_dec (
      .word (cmd_reg),
      .flags(f),
      .idx  (idx)
   );

   sd_rsp_pack #(.W(W), .NWORDS(RSP_WORDS), .LEN_W(LEN_W)) u_pack (
      .rsp_exp (f.rsp_exp),
      .rsp_long(f.rsp_long),
      .rsp_len (rsp_len),
      .rsp_data(rsp_data),
      .cur_resp(resp_flat),
      .ok      (pk_ok),
      .nxt_resp(pk_resp)
   );

   // the stop command is substituted on the bus only; software registers stay put
   assign req_valid = (state == ST_REQ) && !f.clk_only;
   assign req_idx   = in_stop ? STOP_CODE : idx;
   assign req_arg   = in_stop ? '0 : arg_reg;
   assign busy      = (state != ST_IDLE);

   always_comb begin
      load_go = (state == ST_IDLE) && cmd_wr && cmd_wdata[START_BIT];
      finish  = ((state == ST_REQ) && f.clk_only) ||
                ((state == ST_RSP) && rsp_valid);
      fin_ok  = (state == ST_REQ) ? 1'b1 : pk_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         in_stop      <= 1'b0;
         cmd_reg      <= '0;
         arg_reg      <= '0;
         resp_flat    <= '0;
         cmd_done     <= 1'b0;
         no_rsp       <= 1'b0;
         autocmd_done <= 1'b0;
      end else begin
         cmd_done     <= 1'b0;
         no_rsp       <= 1'b0;
         autocmd_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cmd_wr) cmd_reg <= cmd_wdata & ~START_MASK;
               if (arg_wr) arg_reg <= arg_wdata;
               if (load_go) state <= ST_REQ;
            end
            ST_REQ: begin
               if (!f.clk_only && req_ready) state <= ST_RSP;
            end
            ST_RSP: begin
               if (rsp_valid) resp_flat <= pk_resp;
            end
            ST_XWAIT: begin
               if (xfer_zero) begin
                  in_stop <= 1'b1;
                  state   <= ST_REQ;
               end
            end
            default: state <= ST_IDLE;
         endcase
         if (finish) begin
            cmd_done <= fin_ok;
            no_rsp   <= !fin_ok;
            if (in_stop) begin
               autocmd_done <= 1'b1;
               in_stop      <= 1'b0;
               state        <= ST_IDLE;
            end else if (f.auto_stop) begin
               state <= ST_XWAIT;
            end else begin
               state <= ST_IDLE;
            end
         end
      end
   end
endmodule

// File: rtl/sd_cmd_seq_chk.sv
module sd_cmd_seq_chk #(
   parameter int W     = 32,
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_wr,
   input logic [W-1:0]     cmd_wdata,
   input logic             arg_wr,
   input logic             req_valid,
   input logic             req_ready,
   input logic [IDX_W-1:0] req_idx,
   input logic [W-1:0]     req_arg,
   input logic [W-1:0]     cmd_reg,
   input logic [W-1:0]     arg_reg,
   input logic             busy,
   input logic             cmd_done,
   input logic             no_rsp,
   input logic             autocmd_done
);
   // R1
   load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_wr && cmd_wdata[31]) |=> busy);
   // R11
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid);
   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_idx) && $stable(req_arg)));
   // R7
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_done, no_rsp}));
   // R9
   auto_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      autocmd_done |-> (cmd_done || no_rsp));
   // R11
   final_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      autocmd_done |-> !busy);
   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cmd_wr || arg_wr)) |=> ($stable(cmd_reg) && $stable(arg_reg)));
endmodule

bind sd_cmd_seq sd_cmd_seq_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
   .arg_wr(arg_wr), .req_valid(req_valid), .req_ready(req_ready),
   .req_idx(req_idx), .req_arg(req_arg), .cmd_reg(cmd_reg), .arg_reg(arg_reg),
   .busy(busy), .cmd_done(cmd_done), .no_rsp(no_rsp), .autocmd_done(autocmd_done)
);

// File: tb/sd_cmd_seq_test.sv
`timescale 1ns/1ps
module sd_cmd_seq_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_wr = 1'b0, arg_wr = 1'b0, xfer_zero = 1'b1;
   logic [31:0]  cmd_wdata = '0, arg_wdata = '0;
   logic         req_valid, req_ready = 1'b1, rsp_valid = 1'b0;
   logic [5:0]   req_idx;
   logic [31:0]  req_arg, cmd_reg, arg_reg;
   logic [4:0]   rsp_len = '0;
   logic [127:0] rsp_data = '0, resp_flat;
   logic         busy, cmd_done, no_rsp, autocmd_done;

   always #5 clk = ~clk;

   sd_cmd_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .arg_wr(arg_wr), .arg_wdata(arg_wdata), .xfer_zero(xfer_zero),
      .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
      .req_arg(req_arg), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
      .rsp_data(rsp_data), .cmd_reg(cmd_reg), .arg_reg(arg_reg),
      .resp_flat(resp_flat), .busy(busy), .cmd_done(cmd_done),
      .no_rsp(no_rsp), .autocmd_done(autocmd_done)
   );

   typedef struct packed {
      logic [31:0] cmd;
      logic [31:0] arg;
      logic [4:0]  len;
      logic        ok;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h8000_0051, 32'h1234_5678, 5'd4,  1'b1},  // R5 short ok
      '{32'h8000_00C2, 32'h0000_0000, 5'd16, 1'b1},  // R6 long ok
      '{32'h8000_0000, 32'hFFFF_FFFF, 5'd0,  1'b1},  // R8 no response
      '{32'h8000_0048, 32'h0000_01AA, 5'd16, 1'b0},  // R7 short vs 16
      '{32'h8000_00C9, 32'hA5A5_0000, 5'd4,  1'b0},  // R7 long vs 4
      '{32'h8000_0077, 32'h0000_0007, 5'd0,  1'b0},  // R7 none returned
      '{32'h8000_0083, 32'h0BAD_F00D, 5'd16, 1'b1}   // R8 long bit only
   };

   int checks = 0, fails = 0;
   bit finished = 0;
   int stall = 0, poke_at = -1, release_at = -1;
   int nreq, n_done, n_norsp, n_auto;
   logic [5:0]  log_idx [2];
   logic [31:0] log_arg [2];
   int          log_it  [2];
   bit          ended;
   logic [127:0] model;

   function automatic logic [127:0] mk(int s);
      return {32'hF100_0000 + s, 32'h0E20_0000 + s, 32'h00D3_0000 + s, 32'h000C_4000 + s};
   endfunction

   function automatic logic [127:0] as_short(logic [127:0] d);
      return {96'h0, d[127:96]};
   endfunction

   function automatic logic [127:0] as_long(logic [127:0] d);
      logic [127:0] r;
      r[127:96] = d[127:96];  // first arrival -> word 3
      r[95:64]  = d[95:64];
      r[63:32]  = d[63:32];
      r[31:0]   = d[31:0];    // last arrival -> word 0
      return r;
   endfunction

   task automatic chk(input bit cond, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] c, input logic [31:0] a, input bit wr_arg,
                      input logic [4:0] l0, input logic [127:0] d0,
                      input logic [4:0] l1, input logic [127:0] d1);
      bit pend = 0;
      cmd_wr = 1; cmd_wdata = c; arg_wr = wr_arg; arg_wdata = a;
      @(negedge clk);
      nreq = 0; n_done = 0; n_norsp = 0; n_auto = 0; ended = 0;
      for (int i = 0; i < 80; i++) begin
         rsp_valid = 0; cmd_wr = 0; arg_wr = 0;
         if (pend) begin
            rsp_valid = 1;
            rsp_len  = (nreq == 1) ? l0 : l1;
            rsp_data = (nreq == 1) ? d0 : d1;
            pend = 0;
         end
         if (i == release_at) xfer_zero = 1;
         if (i == poke_at) begin
            cmd_wr = 1; cmd_wdata = 32'h8000_003F; arg_wr = 1; arg_wdata = 32'h0000_DEAD;
         end
         if (req_valid && stall > 0) begin stall--; req_ready = 0; end
         else req_ready = 1;
         if (req_valid && req_ready) begin
            if (nreq < 2) begin
               log_idx[nreq] = req_idx; log_arg[nreq] = req_arg; log_it[nreq] = i;
            end
            nreq++; pend = 1;
         end
         n_done  += int'(cmd_done);
         n_norsp += int'(no_rsp);
         n_auto  += int'(autocmd_done);
         if (!busy && !pend) begin ended = 1; break; end
         @(negedge clk);
      end
      rsp_valid = 0; cmd_wr = 0; arg_wr = 0; req_ready = 1;
      poke_at = -1; release_at = -1; stall = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(!busy && !req_valid && !cmd_done && !no_rsp && !autocmd_done, "R11",
          "reset outputs", {busy, req_valid, cmd_done, no_rsp, autocmd_done}, 0);
      chk(resp_flat == 0 && cmd_reg == 0, "R1", "reset regs", resp_flat, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         logic [127:0] d = mk(v);
         if (v == 1) stall = 2;  // R4 hold under back-pressure
         run(t.cmd, t.arg, 1, t.len, d, 5'd0, '0);
         if (t.ok && t.cmd[6]) model = t.cmd[7] ? as_long(d) : as_short(d);
         chk(ended && nreq == 1, "R11", $sformatf("vec%0d requests", v), nreq, 1);
         chk(log_idx[0] == t.cmd[5:0] && log_arg[0] == t.arg, "R4",
             $sformatf("vec%0d req fields", v), {log_idx[0], log_arg[0]}, {t.cmd[5:0], t.arg});
         chk(n_done == int'(t.ok) && n_norsp == int'(!t.ok), t.ok ? "R8" : "R7",
             $sformatf("vec%0d flags", v), {n_done, n_norsp}, {int'(t.ok), int'(!t.ok)});
         chk(resp_flat == model, t.cmd[7] ? "R6" : "R5",
             $sformatf("vec%0d response", v), resp_flat, model);
         chk(cmd_reg == {1'b0, t.cmd[30:0]} && n_auto == 0, "R1",
             $sformatf("vec%0d cmd_reg", v), cmd_reg, {1'b0, t.cmd[30:0]});
      end

      // R3 clock change: no bus request
      run(32'h8020_0045, 32'h0000_0011, 1, 5'd4, mk(9), 5'd0, '0);
      chk(nreq == 0 && n_done == 1 && n_norsp == 0, "R3", "clock change",
          {nreq, n_done}, {32'd0, 32'd1});
      chk(resp_flat == model, "R3", "clock change response", resp_flat, model);

      // R9 auto stop, count already zero
      xfer_zero = 1;
      run(32'h8000_1052, 32'hCAFE_0001, 1, 5'd4, mk(20), 5'd4, mk(21));
      model = as_short(mk(21));
      chk(nreq == 2 && log_idx[1] == 6'd12 && log_arg[1] == 0, "R9", "stop request",
          {nreq, log_idx[1], log_arg[1]}, {32'd2, 6'd12, 32'd0});
      chk(n_done == 2 && n_auto == 1 && n_norsp == 0, "R9", "stop flags",
          {n_done, n_auto}, {32'd2, 32'd1});
      chk(resp_flat == model, "R9", "stop response", resp_flat, model);
      chk(cmd_reg == 32'h0000_1052 && arg_reg == 32'hCAFE_0001, "R10", "registers kept",
          {cmd_reg, arg_reg}, {32'h0000_1052, 32'hCAFE_0001});

      // R9 stop waits for count zero; stop answer mismatched
      xfer_zero = 0; release_at = 10;
      run(32'h8000_1052, 32'h0000_0022, 1, 5'd4, mk(22), 5'd16, mk(23));
      model = as_short(mk(22));
      chk(nreq == 2 && log_it[1] > 10, "R9", "stop deferred", log_it[1], 11);
      chk(n_done == 1 && n_norsp == 1 && n_auto == 1, "R9", "deferred stop flags",
          {n_done, n_norsp, n_auto}, {32'd1, 32'd1, 32'd1});
      chk(resp_flat == model && arg_reg == 32'h0000_0022, "R10", "deferred stop state",
          resp_flat, model);

      // R12 writes while busy ignored
      stall = 3; poke_at = 1;
      run(32'h8000_0043, 32'h0000_0055, 1, 5'd4, mk(30), 5'd0, '0);
      model = as_short(mk(30));
      chk(nreq == 1 && log_idx[0] == 6'd3 && log_arg[0] == 32'h55, "R12", "busy poke request",
          {nreq, log_idx[0]}, {32'd1, 6'd3});
      chk(cmd_reg == 32'h0000_0043 && arg_reg == 32'h0000_0055 && n_done == 1, "R12",
          "busy poke registers", {cmd_reg, arg_reg}, {32'h43, 32'h55});

      // R2 plain write without start bit
      run(32'h0000_0041, 32'h0, 0, 5'd4, mk(40), 5'd0, '0);
      chk(nreq == 0 && n_done == 0 && n_norsp == 0 && !busy, "R2", "no start",
          {nreq, n_done}, 0);
      chk(cmd_reg == 32'h0000_0041 && resp_flat == model, "R2", "no start regs",
          cmd_reg, 32'h41);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule